// File: doc/BRIEF.md
# PLL Fastlock Timeout Controller

This block governs the wide-bandwidth acquisition window that follows the loading of a new frequency word into a synthesizer. When either of its per-pin mode bits is set, a load strobe starts a timer that counts phase-detector comparison ticks. The timer runs for eight times a programmed 7-bit value. While the window is open, the block passes the programmed boosted charge-pump current code through and tells the open-drain damping-resistor switches to pull low. When the count runs out, the current code falls back to the nominal setting and the switches release.

A switch whose mode bit is clear does not follow the timer. It acts as a plain static output driven by its own switch bit, so the same pins can serve band switching or other board control. All outputs are registered and change on the clock edge that samples the stimulus. The analog charge pump and the loop filter lie outside this block.

Top module: `fastlock_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, both switch pull-down enables are 0, the effective current code is 00 and the active flag is 0, whatever the static switch bits are.
- R2: A load strobe sampled with either mode bit at 1 sets the active flag on that same clock edge.
- R3: The window lasts exactly 8*T accepted ticks, where T is the 7-bit timeout value. The active flag clears on the edge that accepts the last tick. Ticks received with no window open have no effect.
- R4: For a pin whose mode bit is 1, the pull-down enable (1 = pin driven low) is 1 exactly while the window is active and 0 otherwise.
- R5: For a pin whose mode bit is 0, the pull-down enable is the inverse of that pin's static switch bit, so a static bit of 0 drives the pin low and a static bit of 1 releases it. This takes effect one edge after the inputs are sampled.
- R6: While the window is active, the effective current code equals the programmed 2-bit code (00 = 100 uA, 01 = 400 uA, 10 = 700 uA, 11 = 900 uA).
- R7: While no window is active, the effective current code is 00 regardless of the programmed code.
- R8: A timeout value of 0, 1 or 2 is treated as 3, giving 24 ticks. The value 127 gives the maximum of 1016 ticks.
- R9: A load strobe with a mode bit set during an active window restarts the count from the full 8*T of the newly sampled value.
- R10: A load strobe sampled with both mode bits at 0 closes any open window and opens no new one.
- R11: A tick that arrives in the same cycle as a load strobe is not counted. The load takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | New frequency word loaded strobe, one cycle |
| tick_i | input | 1 | One comparison-cycle tick, one cycle wide |
| timeout_i | input | 7 | Programmed timeout value T (window = 8*T ticks) |
| fl_mode_i | input | 2 | Per-pin mode: 1 = timer driven, 0 = static |
| sw_static_i | input | 2 | Per-pin static switch bit |
| icp_code_i | input | 2 | Boosted charge-pump current code |
| sw_pull_o | output | 2 | Open-drain pull-down enables, 1 = pin driven low |
| icp_eff_o | output | 2 | Effective charge-pump current code |
| fl_active_o | output | 1 | Fastlock window active |

## Verification
The bench targets the window length at its edges: the clamped minimum for values 0 to 2, the full 1016-tick maximum, and a tick that coincides with the load. An off-by-one counter or a missing clamp would show as a window of 8T plus or minus one tick, or of zero length. It restarts a half-spent window and disarms an open one with a mode-less load. A design that ignored either case would leave the switches low for the wrong span. It mixes a static pin with a timer pin and probes the current code before and after the window. A design that inverted the static sense or leaked the boosted code after expiry would show the error directly on the pins.

// File: rtl/fl_pkg.sv
package fl_pkg;

    localparam int TO_W     = 7;
    localparam int SHIFT    = 3;
    localparam int MIN_TO   = 3;
    localparam int NUM_SW   = 2;
    localparam int ICP_W    = 2;
    localparam int CNT_W    = TO_W + SHIFT;

    typedef enum logic [ICP_W-1:0] {
        ICP_NOM  = 2'b00,
        ICP_X4   = 2'b01,
        ICP_X7   = 2'b10,
        ICP_X9   = 2'b11
    } icp_e;

    typedef struct packed {
        logic timer_mode;
        logic static_bit;
    } sw_cfg_t;

    function automatic logic [TO_W-1:0] clamp_timeout(input logic [TO_W-1:0] raw);
        if (raw < TO_W'(MIN_TO))
            return TO_W'(MIN_TO);
        return raw;
    endfunction

    function automatic logic [CNT_W-1:0] window_len(input logic [TO_W-1:0] raw);
        return {clamp_timeout(raw), {SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/fl_timer.sv
module fl_timer
    import fl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             arm_i,
    input  logic             tick_i,
    input  logic [TO_W-1:0]  timeout_i,
    output logic             active_o,
    output logic             active_next_o
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(((1 << TO_W) - 1) << SHIFT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Load wins over a simultaneous tick (R11); a disarmed load closes the window (R10).
    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = arm_i ? window_len(timeout_i) : '0;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign active_o      = (cnt_q != '0);
    assign active_next_o = (cnt_d != '0);

    // R3: the counter never holds a value outside the programmable range
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= MAX_CNT);

    // R3: an accepted tick removes exactly one from the remaining count
    assert_tick_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R3: without tick or load the remaining count holds
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !tick_i) |=> $stable(cnt_q));

    // R9, R11, R8: an armed load always restarts at the full clamped length
    assert_reload_R9: assert property (@(posedge clk) disable iff (rst)
        (load_i && arm_i) |=> (cnt_q ==
            (($past(timeout_i) < TO_W'(MIN_TO)) ? CNT_W'(MIN_TO) << SHIFT
                                                : CNT_W'($past(timeout_i)) << SHIFT)));

endmodule

// File: rtl/fl_pin_drive.sv
module fl_pin_drive
    import fl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sw_cfg_t cfg_i,
    input  logic    active_next_i,
    output logic    pull_o
);

    logic pull_d;

    always_comb begin
        if (cfg_i.timer_mode) pull_d = active_next_i;
        else                  pull_d = ~cfg_i.static_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) pull_o <= 1'b0;
        else     pull_o <= pull_d;
    end

endmodule

// File: rtl/fl_icp_sel.sv
module fl_icp_sel
    import fl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ICP_W-1:0] code_i,
    input  logic             active_next_i,
    output icp_e             icp_o
);

    icp_e icp_d;

    always_comb begin
        icp_d = active_next_i ? icp_e'(code_i) : ICP_NOM;
    end

    always_ff @(posedge clk) begin
        if (rst) icp_o <= ICP_NOM;
        else     icp_o <= icp_d;
    end

endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl
    import fl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              tick_i,
    input  logic [TO_W-1:0]   timeout_i,
    input  logic [NUM_SW-1:0] fl_mode_i,
    input  logic [NUM_SW-1:0] sw_static_i,
    input  logic [ICP_W-1:0]  icp_code_i,
    output logic [NUM_SW-1:0] sw_pull_o,
    output logic [ICP_W-1:0]  icp_eff_o,
    output logic              fl_active_o
);

    logic arm;
    logic active_next;
    icp_e icp_q;

    assign arm = |fl_mode_i;

    fl_timer u_timer (
        .clk           (clk),
        .rst           (rst),
        .load_i        (load_i),
        .arm_i         (arm),
        .tick_i        (tick_i),
        .timeout_i     (timeout_i),
        .active_o      (fl_active_o),
        .active_next_o (active_next)
    );

    for (genvar g = 0; g < NUM_SW; g++) begin : g_pin
        sw_cfg_t cfg;
        assign cfg.timer_mode = fl_mode_i[g];
        assign cfg.static_bit = sw_static_i[g];

        fl_pin_drive u_pin (
            .clk           (clk),
            .rst           (rst),
            .cfg_i         (cfg),
            .active_next_i (active_next),
            .pull_o        (sw_pull_o[g])
        );

        // R4: a timer-mode pin pulls low exactly while the window is open
        assert_sw_timer_R4: assert property (@(posedge clk) disable iff (rst)
            fl_mode_i[g] |=> (sw_pull_o[g] == fl_active_o));

        // R5: a static-mode pin follows the inverse of its switch bit
        assert_sw_static_R5: assert property (@(posedge clk) disable iff (rst)
            !fl_mode_i[g] |=> (sw_pull_o[g] == !$past(sw_static_i[g])));
    end

    fl_icp_sel u_icp (
        .clk           (clk),
        .rst           (rst),
        .code_i        (icp_code_i),
        .active_next_i (active_next),
        .icp_o         (icp_q)
    );

    assign icp_eff_o = icp_q;

    // R7: nominal current whenever no window is open
    assert_icp_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !fl_active_o |-> (icp_eff_o == ICP_NOM));

    // R6: boosted code tracks the programmed code during the window
    assert_icp_boost_R6: assert property (@(posedge clk) disable iff (rst)
        fl_active_o |-> (icp_eff_o == $past(icp_code_i)));

    // R10: a load with no mode bit set leaves the window closed
    assert_disarm_R10: assert property (@(posedge clk) disable iff (rst)
        (load_i && !arm) |=> !fl_active_o);

    // R2: an armed load opens the window on the next edge
    assert_arm_open_R2: assert property (@(posedge clk) disable iff (rst)
        (load_i && arm) |=> fl_active_o);

endmodule

// File: tb/fastlock_ctrl_test.sv
`timescale 1ns/1ps
module fastlock_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] tmo = 7'd0;
    logic [1:0] mode = 2'b00;
    logic [1:0] stat = 2'b00;
    logic [1:0] code = 2'b00;
    logic [1:0] pull;
    logic [1:0] icp;
    logic       act;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fastlock_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .tick_i      (tick),
        .timeout_i   (tmo),
        .fl_mode_i   (mode),
        .sw_static_i (stat),
        .icp_code_i  (code),
        .sw_pull_o   (pull),
        .icp_eff_o   (icp),
        .fl_active_o (act)
    );

    // Behavioural reference: remaining ticks as a plain integer
    int       m_rem  = 0;
    bit [1:0] m_pull = 2'b00;
    bit [1:0] m_icp  = 2'b00;

    always @(posedge clk) begin
        if (rst) begin
            m_rem = 0; m_pull = 2'b00; m_icp = 2'b00;
        end else begin
            if (load) begin
                if (mode != 2'b00) m_rem = ((int'(tmo) < 3) ? 3 : int'(tmo)) * 8;
                else               m_rem = 0;
            end else if (tick && m_rem > 0) begin
                m_rem = m_rem - 1;
            end
            for (int i = 0; i < 2; i++)
                m_pull[i] = mode[i] ? (m_rem > 0) : !stat[i];
            m_icp = (m_rem > 0) ? code : 2'b00;
        end
    end

    task automatic chk(input bit ok, input string req, input int actv, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actv, expv, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(act == (m_rem > 0), "R3 active flag", act, m_rem > 0);
            for (int i = 0; i < 2; i++)
                chk(pull[i] == m_pull[i], mode[i] ? "R4 timer pin" : "R5 static pin",
                    pull[i], m_pull[i]);
            chk(icp == m_icp, (m_rem > 0) ? "R6 boosted code" : "R7 nominal code",
                icp, m_icp);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Load then tick every cycle; returns number of sampled cycles with active high
    task automatic window(input bit [6:0] t, input bit [1:0] md, input bit [1:0] cd,
                          input bit tick_at_load, output int n);
        @(negedge clk);
        load = 1'b1; tmo = t; mode = md; code = cd; tick = tick_at_load;
        @(negedge clk);
        load = 1'b0; tick = 1'b1;
        n = 0;
        while (act && n < 2000) begin
            n++;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    initial begin
        int n;
        // R1: reset state with static bits 0 that would otherwise pull low
        idle(2);
        chk(pull == 2'b00, "R1 reset pull", pull, 0);
        chk(icp == 2'b00, "R1 reset icp", icp, 0);
        chk(act == 1'b0, "R1 reset active", act, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(act == 1'b0, "R1 after reset active", act, 0);

        // R3: ticks with no window leave it closed
        stat = 2'b11;
        tick = 1'b1; idle(5); tick = 1'b0;
        chk(act == 1'b0, "R3 stray ticks", act, 0);

        // R2, R3, R4, R6: T=5, both pins timer driven, code 10
        @(negedge clk);
        load = 1'b1; tmo = 7'd5; mode = 2'b11; code = 2'b10;
        @(negedge clk);
        load = 1'b0;
        chk(act == 1'b1, "R2 window opens", act, 1);
        chk(pull == 2'b11, "R4 pins low in window", pull, 3);
        chk(icp == 2'b10, "R6 code 10 passed", icp, 2);
        tick = 1'b1;
        n = 1;
        while (act && n < 2000) begin @(negedge clk); if (act) n++; end
        tick = 1'b0;
        chk(n == 40, "R3 length 8*5", n, 40);
        chk(pull == 2'b00, "R4 pins released", pull, 0);
        chk(icp == 2'b00, "R7 code forced 00", icp, 0);

        // R8: clamp and maximum
        window(7'd0, 2'b01, 2'b11, 1'b0, n);   chk(n == 24, "R8 T=0", n, 24);
        window(7'd2, 2'b10, 2'b01, 1'b0, n);   chk(n == 24, "R8 T=2", n, 24);
        window(7'd3, 2'b11, 2'b01, 1'b0, n);   chk(n == 24, "R8 T=3", n, 24);
        window(7'd127, 2'b11, 2'b11, 1'b0, n); chk(n == 1016, "R8 T=127", n, 1016);

        // R11: tick during the load cycle is not counted
        window(7'd5, 2'b11, 2'b01, 1'b1, n);   chk(n == 40, "R11 load beats tick", n, 40);

        // R5: static mode both polarities, mixed with timer pin
        mode = 2'b00; stat = 2'b01; idle(2);
        chk(pull == 2'b10, "R5 static 01", pull, 2);
        stat = 2'b10; idle(2);
        chk(pull == 2'b01, "R5 static 10", pull, 1);
        mode = 2'b01; stat = 2'b00; idle(2);
        chk(pull == 2'b10, "R5 mixed idle", pull, 2);

        // R9: restart mid-window
        @(negedge clk);
        load = 1'b1; tmo = 7'd4; code = 2'b01;
        @(negedge clk);
        load = 1'b0; tick = 1'b1;
        idle(20);
        tick = 1'b0; load = 1'b1;
        @(negedge clk);
        load = 1'b0; tick = 1'b1;
        n = 0;
        while (act && n < 2000) begin n++; @(negedge clk); end
        tick = 1'b0;
        chk(n == 32, "R9 restart full length", n, 32);

        // R10: disarmed load closes an open window
        @(negedge clk);
        load = 1'b1; tmo = 7'd10; mode = 2'b11;
        @(negedge clk);
        load = 1'b1; mode = 2'b00;
        @(negedge clk);
        load = 1'b0;
        chk(act == 1'b0, "R10 disarm closes", act, 0);
        chk(icp == 2'b00, "R10 code nominal", icp, 0);

        // Sparse ticks, compared cycle by cycle against the model
        @(negedge clk);
        load = 1'b1; tmo = 7'd3; mode = 2'b10; code = 2'b11;
        @(negedge clk);
        load = 1'b0;
        for (int i = 0; i < 100; i++) begin
            tick = (i % 3 == 0);
            @(negedge clk);
        end
        tick = 1'b0;
        idle(3);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule